// File: doc/BRIEF.md
# Multi-Width Serial Flash Bus Engine

This block is a bus controller for serial peripheral devices, mostly memories, that speak SPI over one, two or four data lines. A host pushes a stream of operations into it on a valid/ready port: open a transaction on a chosen chip select, shift one byte out, shift one byte in, swap one byte at single width, clock a number of dummy cycles, wait a number of microseconds, close the transaction, or ask for a sync acknowledge. Bytes that are read come back on a response stream that holds each byte until the host takes it.

The engine drives SCK, eight active-low chip selects and four data lines, each with its own output enable. SCK is derived from the system clock through a divisor that can only change while no transaction is open. The chip select is deferred: opening a transaction only records the line, and the line falls at the first operation that really clocks the bus. An opened and closed transaction with no transfer in between never touches the chip selects. Illegal requests are answered with a one-cycle error pulse and have no effect on the bus.

Top module: `qspi_engine`

## Requirements
- R1: After reset all chip selects are high, SCK is low, every output enable is off, cmd_ready is high and rsp_valid is low.
- R2: A write (cmd_op 1) shifts cmd_arg[7:0] MSB first in SPI mode 0 (SCK idles low, new data after each falling edge, stable at each rising edge). cmd_width 0 uses IO0 alone for 8 SCK cycles with output enables 0001; width 1 uses IO1:IO0 (IO1 carries the higher bit) for 4 cycles with enables 0011; width 2 uses IO3:IO0 (IO3 highest) for 2 cycles with enables 1111.
- R3: A read (cmd_op 2) samples the lines on each rising SCK edge, MSB first: width 0 samples IO1 only for 8 cycles while IO0 stays an enabled output (enables 0001); width 1 samples IO1:IO0 for 4 cycles and width 2 samples IO3:IO0 for 2 cycles, both with all enables off. The assembled byte appears on rsp_data.
- R4: An exchange (cmd_op 3) ignores cmd_width, drives cmd_arg[7:0] on IO0 and samples IO1 in the same 8 SCK cycles, returning the sampled byte on rsp_data.
- R5: A start (cmd_op 0) with cmd_arg 0 to 7 opens a transaction; its first transfer pulls exactly cs_n[cmd_arg] low, and only that line. A start with cmd_arg above 7, or a start while a transaction is open, raises op_error for one cycle and changes nothing.
- R6: Chip select falls only at the first write, read, exchange or dummy of a transaction; an end (cmd_op 6) raises every chip select and closes the transaction, so a start followed directly by an end produces no chip select activity.
- R7: A write, read, exchange or dummy issued with no open transaction raises op_error for one cycle and produces no SCK edge.
- R8: A dummy (cmd_op 4) clocks exactly cmd_arg SCK cycles, any count, with every output enable off.
- R9: Each SCK phase, high and low, lasts div_val+1 system clocks; a div_we write is taken only while no transaction is open and ignored otherwise.
- R10: A delay (cmd_op 5) keeps cmd_ready low for cmd_arg times CLK_PER_US system clocks before the next operation is accepted.
- R11: A sync (cmd_op 7) pulses sync_ack only after every earlier operation has finished on the bus.
- R12: rsp_valid with its rsp_data stays unchanged until rsp_ready is seen, and no new operation is accepted meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Operation request valid |
| cmd_ready | output | 1 | Engine can accept an operation |
| cmd_op | input | 3 | Operation code |
| cmd_width | input | 2 | Lane width code: 0 x1, 1 x2, 2 x4 |
| cmd_arg | input | 16 | Byte, chip index, cycle count or microsecond count |
| rsp_valid | output | 1 | Read byte available |
| rsp_ready | input | 1 | Host takes the read byte |
| rsp_data | output | 8 | Read byte |
| sync_ack | output | 1 | One-cycle sync acknowledge |
| op_error | output | 1 | One-cycle pulse for a rejected operation |
| div_we | input | 1 | Divisor write strobe |
| div_val | input | 8 | New SCK divisor |
| sck | output | 1 | Serial clock |
| cs_n | output | 8 | Active-low chip selects |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
The byte shifter is tried with a table of writes, reads and exchanges at every width, using bytes such as A5, 3C, 96, C3 and E1 whose bit patterns differ in every nibble and half-nibble, so a swapped lane, a reversed bit order or a wrong beat count each yields a different byte and a different SCK edge count. A device model in the bench shifts its reply on falling SCK edges and captures controller data on rising edges, which separates sampling on the wrong edge from correct mode 0 timing. Directed sequences then cover the deferred chip select, each kind of rejected request, an odd dummy count, two divisor settings and a locked divisor write, a delay length, sync ordering and response back-pressure.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_WRITE = 3'd1,
        OP_READ  = 3'd2,
        OP_XCHG  = 3'd3,
        OP_DUMMY = 3'd4,
        OP_DELAY = 3'd5,
        OP_END   = 3'd6,
        OP_SYNC  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LW_X1 = 2'd0,
        LW_X2 = 2'd1,
        LW_X4 = 2'd2,
        LW_RSV = 2'd3
    } lane_w_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_WAIT = 2'd3
    } eng_st_e;

    typedef struct packed {
        op_e     op;
        lane_w_e w;
    } xfer_ctx_t;

    function automatic logic [3:0] beats_per_byte(lane_w_e w);
        case (w)
            LW_X2:   return 4'd4;
            LW_X4:   return 4'd2;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(op_e op, lane_w_e w);
        case (op)
            OP_WRITE: begin
                case (w)
                    LW_X2:   return 4'b0011;
                    LW_X4:   return 4'b1111;
                    default: return 4'b0001;
                endcase
            end
            OP_READ:  return (w == LW_X2 || w == LW_X4) ? 4'b0000 : 4'b0001;
            OP_XCHG:  return 4'b0001;
            default:  return 4'b0000;
        endcase
    endfunction

    function automatic logic is_transfer(op_e op);
        return (op == OP_WRITE) || (op == OP_READ) || (op == OP_XCHG) || (op == OP_DUMMY);
    endfunction

    function automatic logic returns_byte(op_e op);
        return (op == OP_READ) || (op == OP_XCHG);
    endfunction

endpackage

// File: rtl/qspi_halfbeat.sv
module qspi_halfbeat #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div)); // R9

endmodule

// File: rtl/qspi_lane_shifter.sv
module qspi_lane_shifter
    import qspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       advance,
    input  logic       sample,
    input  lane_w_e    w,
    input  logic [3:0] io_in,
    output logic [3:0] lane_out,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_sh;
    logic [7:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
        end else if (load) begin
            tx_sh <= load_byte;
        end else if (advance) begin
            case (w)
                LW_X2:   tx_sh <= {tx_sh[5:0], 2'b00};
                LW_X4:   tx_sh <= {tx_sh[3:0], 4'b0000};
                default: tx_sh <= {tx_sh[6:0], 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh <= '0;
        end else if (load) begin
            rx_sh <= '0;
        end else if (sample) begin
            case (w)
                LW_X2:   rx_sh <= {rx_sh[5:0], io_in[1:0]};
                LW_X4:   rx_sh <= {rx_sh[3:0], io_in[3:0]};
                default: rx_sh <= {rx_sh[6:0], io_in[1]};
            endcase
        end
    end

    always_comb begin
        case (w)
            LW_X2:   lane_out = {2'b00, tx_sh[7:6]};
            LW_X4:   lane_out = tx_sh[7:4];
            default: lane_out = {3'b000, tx_sh[7]};
        endcase
    end

    assign rx_byte = rx_sh;

    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        load |-> !(advance || sample)); // R2

endmodule

// File: rtl/qspi_cs_tracker.sv
module qspi_cs_tracker #(
    parameter int NUM_CS = 8,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_req,
    input  logic [IDX_W-1:0]  open_idx,
    input  logic              close_req,
    input  logic              xfer_go,
    output logic              xact_open,
    output logic [NUM_CS-1:0] cs_n
);
    logic             open_q;
    logic [IDX_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            sel_q  <= '0;
        end else if (close_req) begin
            open_q <= 1'b0;
        end else if (open_req) begin
            open_q <= 1'b1;
            sel_q  <= open_idx;
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst || close_req) begin
                cs_n[i] <= 1'b1;
            end else if (xfer_go && (sel_q == IDX_W'(i))) begin
                cs_n[i] <= 1'b0;
            end
        end
    end

    assign xact_open = open_q;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n)); // R5

    AST_CS_NEEDS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cs_n != {NUM_CS{1'b1}}) |-> open_q); // R6

endmodule

// File: rtl/qspi_delay_timer.sv
module qspi_delay_timer #(
    parameter int ARG_W      = 16,
    parameter int CLK_PER_US = 100,
    localparam int SUB_W     = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ARG_W-1:0] us,
    output logic             done
);
    logic             active;
    logic [SUB_W-1:0] sub;
    logic [ARG_W-1:0] us_left;
    logic             sub_wrap;

    assign sub_wrap = (sub == SUB_W'(CLK_PER_US - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            sub     <= '0;
            us_left <= '0;
        end else if (start) begin
            active  <= 1'b1;
            sub     <= '0;
            us_left <= us;
        end else if (active) begin
            if (sub_wrap) begin
                sub <= '0;
                if (us_left == ARG_W'(1)) begin
                    active <= 1'b0;
                end else begin
                    us_left <= us_left - 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign done = active && sub_wrap && (us_left == ARG_W'(1));

    AST_DLY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        active |-> !start); // R10

endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
    import qspi_pkg::*;
#(
    parameter int NUM_CS     = 8,
    parameter int DIV_W      = 8,
    parameter int ARG_W      = 16,
    parameter int CLK_PER_US = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_width,
    input  logic [ARG_W-1:0]  cmd_arg,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [7:0]        rsp_data,
    output logic              sync_ack,
    output logic              op_error,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_val,
    output logic              sck,
    output logic [NUM_CS-1:0] cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    eng_st_e          st;
    xfer_ctx_t        ctx_q;
    logic [ARG_W-1:0] cyc_left;
    logic [DIV_W-1:0] div_q;
    logic             rsp_valid_q;
    logic             err_q;
    logic             ack_q;

    op_e              in_op;
    lane_w_e          in_w;
    lane_w_e          eff_w;
    logic             fire;
    logic             xact_open;
    logic             idx_ok;
    logic             open_req;
    logic             close_req;
    logic             xfer_req;
    logic             dly_start;
    logic             dly_done;
    logic             tick;
    logic             in_xfer;
    logic             last_beat;
    logic             sample;
    logic             advance;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic [3:0]       lane_out;
    logic [ARG_W-1:0] first_beats;

    // ---------------- request decode ----------------
    assign in_op     = op_e'(cmd_op);
    assign in_w      = lane_w_e'(cmd_width);
    assign cmd_ready = (st == ST_IDLE) && !rsp_valid_q;
    assign fire      = cmd_valid && cmd_ready;
    assign idx_ok    = (cmd_arg < ARG_W'(NUM_CS));

    assign open_req  = fire && (in_op == OP_START) && !xact_open && idx_ok;
    assign close_req = fire && (in_op == OP_END);
    assign xfer_req  = fire && is_transfer(in_op) && xact_open &&
                       !((in_op == OP_DUMMY) && (cmd_arg == '0));
    assign dly_start = fire && (in_op == OP_DELAY) && (cmd_arg != '0);

    assign eff_w       = ((in_op == OP_WRITE) || (in_op == OP_READ)) ? in_w : LW_X1;
    assign first_beats = (in_op == OP_DUMMY) ? cmd_arg : ARG_W'(beats_per_byte(eff_w));
    assign tx_byte     = ((in_op == OP_WRITE) || (in_op == OP_XCHG)) ? cmd_arg[7:0] : 8'h00;

    // ---------------- phase control ----------------
    assign in_xfer   = (st == ST_LOW) || (st == ST_HIGH);
    assign last_beat = (cyc_left == ARG_W'(1));
    assign sample    = (st == ST_LOW) && tick;
    assign advance   = (st == ST_HIGH) && tick && !last_beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            ctx_q       <= '{op: OP_WRITE, w: LW_X1};
            cyc_left    <= '0;
            div_q       <= '0;
            rsp_valid_q <= 1'b0;
            err_q       <= 1'b0;
            ack_q       <= 1'b0;
        end else begin
            err_q <= 1'b0;
            ack_q <= 1'b0;
            if (rsp_valid_q && rsp_ready) begin
                rsp_valid_q <= 1'b0;
            end
            if (div_we && !xact_open) begin
                div_q <= div_val;
            end
            case (st)
                ST_IDLE: begin
                    if (fire) begin
                        case (in_op)
                            OP_START: begin
                                if (xact_open || !idx_ok) begin
                                    err_q <= 1'b1;
                                end
                            end
                            OP_SYNC: ack_q <= 1'b1;
                            OP_DELAY: begin
                                if (dly_start) begin
                                    st <= ST_WAIT;
                                end
                            end
                            OP_END: ;
                            default: begin
                                if (!xact_open) begin
                                    err_q <= 1'b1;
                                end else if (xfer_req) begin
                                    st       <= ST_LOW;
                                    ctx_q    <= '{op: in_op, w: eff_w};
                                    cyc_left <= first_beats;
                                end
                            end
                        endcase
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        st <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (last_beat) begin
                            st <= ST_IDLE;
                            if (returns_byte(ctx_q.op)) begin
                                rsp_valid_q <= 1'b1;
                            end
                        end else begin
                            st       <= ST_LOW;
                            cyc_left <= cyc_left - 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (dly_done) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // ---------------- submodules ----------------
    qspi_halfbeat #(.DIV_W(DIV_W)) u_halfbeat (
        .clk     (clk),
        .rst     (rst),
        .run     (in_xfer),
        .restart (xfer_req),
        .div     (div_q),
        .tick    (tick)
    );

    qspi_lane_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (xfer_req),
        .load_byte (tx_byte),
        .advance   (advance),
        .sample    (sample),
        .w         (ctx_q.w),
        .io_in     (io_in),
        .lane_out  (lane_out),
        .rx_byte   (rx_byte)
    );

    qspi_cs_tracker #(.NUM_CS(NUM_CS)) u_cs (
        .clk       (clk),
        .rst       (rst),
        .open_req  (open_req),
        .open_idx  (cmd_arg[IDX_W-1:0]),
        .close_req (close_req),
        .xfer_go   (xfer_req),
        .xact_open (xact_open),
        .cs_n      (cs_n)
    );

    qspi_delay_timer #(.ARG_W(ARG_W), .CLK_PER_US(CLK_PER_US)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .start (dly_start),
        .us    (cmd_arg),
        .done  (dly_done)
    );

    // ---------------- outputs ----------------
    assign sck       = (st == ST_HIGH);
    assign io_oe     = in_xfer ? lane_mask(ctx_q.op, ctx_q.w) : 4'b0000;
    assign io_out    = lane_out;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rx_byte;
    assign op_error  = err_q;
    assign sync_ack  = ack_q;

    // ---------------- assertions ----------------
    AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        sck |-> (cs_n != {NUM_CS{1'b1}})); // R7

    AST_ORPHAN_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fire && is_transfer(in_op) && !xact_open) |=> (st == ST_IDLE) && op_error); // R7

    AST_DUMMY_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        (sck && (ctx_q.op == OP_DUMMY)) |-> (io_oe == 4'b0000)); // R8

    AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (rst)
        xact_open |=> $stable(div_q)); // R9

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data)); // R12

    AST_RSP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cmd_ready); // R12

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        sync_ack |-> !sck && (io_oe == 4'b0000)); // R11

endmodule

// File: tb/qspi_engine_bench.sv
module qspi_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_width = 2'd0;
    logic [15:0] cmd_arg = 16'd0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [7:0]  rsp_data;
    logic        sync_ack;
    logic        op_error;
    logic        div_we = 1'b0;
    logic [7:0]  div_val = 8'd0;
    logic        sck;
    logic [7:0]  cs_n;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;
    logic [3:0]  io_in;

    always #5 clk = ~clk;

    qspi_engine u_qspi_engine (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_width(cmd_width), .cmd_arg(cmd_arg),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .sync_ack(sync_ack), .op_error(op_error),
        .div_we(div_we), .div_val(div_val),
        .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // ---------------- device model ----------------
    logic [1:0]  mw = 2'd0;
    logic [7:0]  dev_byte = 8'h00;
    int          fall_base = 0;
    int          fall_cnt = 0;
    int          rise_cnt = 0;
    int          err_cnt = 0;
    int          ack_cnt = 0;
    int          rise_at_ack = 0;
    int          cs_low_cnt = 0;
    int          hi_run = 0;
    int          last_hi = 0;
    logic [7:0]  cap = 8'h00;
    logic [3:0]  last_oe = 4'h0;
    logic [31:0] dev_view;

    assign dev_view = {24'h0, dev_byte} << ((fall_cnt - fall_base) * (1 << mw));
    assign io_in = (mw == 2'd2) ? dev_view[7:4] :
                   (mw == 2'd1) ? {2'b00, dev_view[7:6]} :
                                  {2'b00, dev_view[7], 1'b0};

    always @(posedge sck) begin
        rise_cnt <= rise_cnt + 1;
        last_oe  <= io_oe;
        case (mw)
            2'd1:    cap <= {cap[5:0], io_out[1:0]};
            2'd2:    cap <= {cap[3:0], io_out[3:0]};
            default: cap <= {cap[6:0], io_out[0]};
        endcase
    end

    always @(negedge sck) fall_cnt <= fall_cnt + 1;

    always @(posedge clk) begin
        if (op_error) err_cnt <= err_cnt + 1;
        if (sync_ack) begin
            ack_cnt     <= ack_cnt + 1;
            rise_at_ack <= rise_cnt;
        end
        if (cs_n != 8'hFF) cs_low_cnt <= cs_low_cnt + 1;
        if (sck) hi_run <= hi_run + 1;
        else if (hi_run != 0) begin
            last_hi <= hi_run;
            hi_run  <= 0;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [1:0] w, input logic [15:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_width = w;
        cmd_arg   = arg;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(cmd_ready || rsp_valid)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic pop(output logic [7:0] got);
        @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        got = rsp_data;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] v);
        @(negedge clk);
        div_we  = 1'b1;
        div_val = v;
        @(negedge clk);
        div_we  = 1'b0;
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [2:0] op;
        logic [1:0] w;
        logic [7:0] data;
        logic [7:0] dev;
        logic [3:0] oe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 2'd0, 8'hA5, 8'h00, 4'b0001},
        '{3'd1, 2'd1, 8'h3C, 8'h00, 4'b0011},
        '{3'd1, 2'd2, 8'h96, 8'h00, 4'b1111},
        '{3'd2, 2'd0, 8'h00, 8'hC3, 4'b0001},
        '{3'd2, 2'd1, 8'h00, 8'h5A, 4'b0000},
        '{3'd2, 2'd2, 8'h00, 8'hE1, 4'b0000},
        '{3'd3, 2'd2, 8'h81, 8'h7E, 4'b0001},
        '{3'd1, 2'd2, 8'h4B, 8'h00, 4'b1111}
    };

    vec_t        v;
    logic [1:0]  ew;
    logic [7:0]  got;
    int          r0, e0, c0, n;

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(cs_n == 8'hFF, "R1 cs_n", cs_n, 8'hFF);
        chk(sck == 1'b0 && io_oe == 4'h0, "R1 sck/oe", {sck, io_oe}, 0);
        chk(cmd_ready && !rsp_valid, "R1 ready/valid", {cmd_ready, rsp_valid}, 2'b10);

        // R7 transfer outside a transaction
        e0 = err_cnt; r0 = rise_cnt;
        send(3'd1, 2'd0, 16'h00AA);
        wait_idle();
        chk(err_cnt == e0 + 1, "R7 error pulse", err_cnt - e0, 1);
        chk(rise_cnt == r0, "R7 no sck", rise_cnt - r0, 0);

        // R6 empty transaction
        c0 = cs_low_cnt; e0 = err_cnt;
        send(3'd0, 2'd0, 16'd3);
        send(3'd6, 2'd0, 16'd0);
        wait_idle();
        chk(cs_low_cnt == c0, "R6 empty transaction cs", cs_low_cnt - c0, 0);
        chk(err_cnt == e0, "R6 empty transaction no error", err_cnt - e0, 0);

        // R5 bad index, nested start
        e0 = err_cnt;
        send(3'd0, 2'd0, 16'd9);
        wait_idle();
        chk(err_cnt == e0 + 1, "R5 index above 7", err_cnt - e0, 1);
        send(3'd0, 2'd0, 16'd2);
        send(3'd0, 2'd0, 16'd1);
        wait_idle();
        chk(err_cnt == e0 + 2, "R5 nested start", err_cnt - e0, 2);
        chk(cs_n == 8'hFF, "R6 deferred cs", cs_n, 8'hFF);

        // R2 R3 R4 table
        for (int i = 0; i < NV; i++) begin
            v  = VECS[i];
            ew = (v.op == 3'd3) ? 2'd0 : v.w;
            mw = ew;
            dev_byte  = v.dev;
            fall_base = fall_cnt;
            r0 = rise_cnt;
            send(v.op, v.w, {8'h00, v.data});
            if (v.op == 3'd1) wait_idle();
            else pop(got);
            chk(rise_cnt - r0 == (8 >> ew), "R2 beat count", rise_cnt - r0, 8 >> ew);
            chk(last_oe == v.oe, "R3 output enables", last_oe, v.oe);
            if (v.op != 3'd2)
                chk(cap == v.data, "R2 R4 data on lines", cap, v.data);
            if (v.op != 3'd1)
                chk(got == v.dev, "R3 R4 byte returned", got, v.dev);
        end
        chk(cs_n == 8'hFB, "R5 selected line 2", cs_n, 8'hFB);

        // R8 dummy with odd count
        r0 = rise_cnt; mw = 2'd0;
        send(3'd4, 2'd0, 16'd5);
        wait_idle();
        chk(rise_cnt - r0 == 5, "R8 dummy count", rise_cnt - r0, 5);
        chk(last_oe == 4'h0, "R8 dummy oe off", last_oe, 0);

        // R9 divisor locked while open
        set_div(8'd7);
        mw = 2'd2;
        send(3'd1, 2'd2, 16'h0011);
        wait_idle();
        chk(last_hi == 1, "R9 locked divisor", last_hi, 1);
        send(3'd6, 2'd0, 16'd0);
        wait_idle();
        chk(cs_n == 8'hFF, "R6 end deasserts", cs_n, 8'hFF);

        // R9 divisor 3
        set_div(8'd3);
        send(3'd0, 2'd0, 16'd0);
        send(3'd1, 2'd2, 16'h0022);
        wait_idle();
        chk(last_hi == 4, "R9 half period div+1", last_hi, 4);
        chk(cs_n == 8'hFE, "R5 selected line 0", cs_n, 8'hFE);
        send(3'd6, 2'd0, 16'd0);
        set_div(8'd0);

        // R10 delay
        send(3'd5, 2'd0, 16'd2);
        n = 0;
        while (!cmd_ready) begin
            n++;
            @(negedge clk);
        end
        chk(n == 200, "R10 delay length", n, 200);

        // R11 sync after write
        mw = 2'd0;
        send(3'd0, 2'd0, 16'd1);
        r0 = rise_cnt; c0 = ack_cnt;
        send(3'd1, 2'd0, 16'h0077);
        send(3'd7, 2'd0, 16'd0);
        wait_idle();
        chk(ack_cnt == c0 + 1, "R11 sync ack", ack_cnt - c0, 1);
        chk(rise_at_ack - r0 == 8, "R11 ack after write", rise_at_ack - r0, 8);

        // R12 response back-pressure
        dev_byte = 8'h69; fall_base = fall_cnt;
        send(3'd2, 2'd0, 16'd0);
        @(negedge clk);
        while (!rsp_valid) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(rsp_valid && !cmd_ready, "R12 held valid", {rsp_valid, cmd_ready}, 2'b10);
        chk(rsp_data == 8'h69, "R12 held data", rsp_data, 8'h69);
        pop(got);
        @(negedge clk);
        chk(!rsp_valid && cmd_ready, "R12 released", {rsp_valid, cmd_ready}, 2'b01);
        send(3'd6, 2'd0, 16'd0);
        wait_idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule